// File: doc/BRIEF.md
# Configuration Guard and Host Supervisor

This block sits on a simple synchronous register bus (address, write strobe, write data, combinational read data). It protects a bank of configuration registers elsewhere in the chip. A single unlock key written to a key register raises a write-enable qualifier. Any other value written there drops the qualifier again. The block also includes a scratch byte that the host can use to test bus access. The scratch byte obeys the same qualifier and has no other effect.

A watchdog supervises the host processor. The host must write three watchdog registers in a fixed order, each with its own fixed value, and must complete that sequence before a supervision window expires. If the window runs out, the block drives a processor reset pulse of programmable length and then starts a fresh window. The window is built from a clock prescaler and a tick counter, so the default of about two seconds can be reduced to a few cycles for simulation.

A 16-bit down-counting timer is loaded through a staged high byte and a low byte. It counts down once per prescaled period, stops at zero and raises a sticky expiry flag.

Top module: `cfg_guard`

## Requirements
- R1: After reset the write qualifier `cfg_wr_ok` is 0, `host_reset` is 0, `tmr_expired` is 0, the scratch byte reads 0x00 and the timer count reads 0x0000.
- R2: A write of 0x95 to address 1 (key register) sets `cfg_wr_ok` from the next clock on, and address 1 reads back `{7'b0, cfg_wr_ok}`.
- R3: A write of any value other than 0x95 to address 1 clears `cfg_wr_ok` from the next clock on. No other bus activity changes `cfg_wr_ok`.
- R4: The scratch byte at address 0 takes the written data only while `cfg_wr_ok` is 1. Otherwise the write is ignored, and the scratch byte affects no other output.
- R5: The watchdog is serviced by writing WD_VAL1 (0x5A) to address 2, then WD_VAL2 (0x99) to address 3, then WD_VAL3 (0xA5) to address 4. The clock edge that takes the final write restarts the supervision window from zero.
- R6: A watchdog-register write with the wrong value or in the wrong position returns the sequence to its first step without crediting that write. An incomplete sequence does not restart the window.
- R7: If no sequence completes for PRESC_DIV*WIN_TICKS clocks after the window starts, `host_reset` rises on the clock edge that ends the window.
- R8: `host_reset` stays high for exactly RST_LEN clocks. Bus writes to the watchdog are ignored during the pulse, and a new full window starts on the clock edge where the pulse ends.
- R9: While `wd_disable` is 1, `host_reset` is 0, the window counters are held at zero and the sequence is held at its first step. The window restarts in full when `wd_disable` falls.
- R10: A write to address 5 stages the timer's high byte. A write to address 6 loads the count as {staged high, written low}, restarts the timer prescaler and clears `tmr_expired`. Addresses 5 and 6 read the current count's high and low bytes, and address 7 reads `{7'b0, tmr_expired}`.
- R11: A nonzero count decrements once every TMR_PRESC clocks after a load and stops at zero. `tmr_expired` rises on the edge where the count reaches zero, or on a load of zero.
- R12: `tmr_expired` stays set, and the count stays at zero, until the next write to address 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| wd_disable | input | 1 | Holds the watchdog inactive while high |
| cfg_wr_ok | output | 1 | Write-enable qualifier for protected registers |
| host_reset | output | 1 | Active-high processor reset pulse |
| tmr_expired | output | 1 | Sticky timer-zero flag |

## Verification
The bench builds the block with PRESC_DIV=4, WIN_TICKS=8, RST_LEN=5 and TMR_PRESC=3. This gives a 32-cycle supervision window and a timer step of three cycles. With these values, many window expiries, reset pulses and rearms fit in a short run. The exact edge of an expiry after a partial or wrong sequence can be measured directly, and timer countdowns to zero finish in tens of cycles. A cycle-level reference model, written from the requirements, runs next to directed cases while random bus traffic hits the key, the watchdog values and the timer.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;

    localparam int ADDR_W = 3;
    localparam logic [7:0] UNLOCK_KEY = 8'h95;

    typedef enum logic [ADDR_W-1:0] {
        A_SCRATCH = 3'd0,
        A_KEY     = 3'd1,
        A_WD1     = 3'd2,
        A_WD2     = 3'd3,
        A_WD3     = 3'd4,
        A_TMR_HI  = 3'd5,
        A_TMR_LO  = 3'd6,
        A_TFLAG   = 3'd7
    } addr_e;

    typedef enum logic [1:0] {
        WD_STEP0 = 2'd0,
        WD_STEP1 = 2'd1,
        WD_STEP2 = 2'd2
    } wd_step_e;

endpackage

// File: rtl/wp_key_unit.sv
module wp_key_unit
    import cfg_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] wdata,
    output logic       unlocked
);

    typedef struct packed {
        logic open;
    } key_st_t;

    key_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (key_wr) begin
            st_d.open = (wdata == UNLOCK_KEY);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign unlocked = st_q.open;

endmodule

// File: rtl/wd_supervisor.sv
module wd_supervisor
    import cfg_guard_pkg::*;
#(
    parameter int         PRESC_DIV = 2_000_000,
    parameter int         WIN_TICKS = 100,
    parameter int         RST_LEN   = 16,
    parameter logic [7:0] WD_VAL1   = 8'h5A,
    parameter logic [7:0] WD_VAL2   = 8'h99,
    parameter logic [7:0] WD_VAL3   = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic              host_rst
);

    localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
    localparam int WW = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;
    localparam int LW = (RST_LEN > 1) ? $clog2(RST_LEN) : 1;
    localparam logic [PW-1:0] PRESC_LAST = PW'(PRESC_DIV - 1);
    localparam logic [WW-1:0] WIN_LAST   = WW'(WIN_TICKS - 1);
    localparam logic [LW-1:0] LEN_LOAD   = LW'(RST_LEN - 1);

    typedef struct packed {
        wd_step_e        step;
        logic [PW-1:0]   presc;
        logic [WW-1:0]   win;
        logic            pulse;
        logic [LW-1:0]   plen;
    } wd_st_t;

    wd_st_t st_d, st_q;

    logic hit1, hit2, hit3, any_hit, done;

    always_comb begin
        hit1    = wr && (addr == A_WD1);
        hit2    = wr && (addr == A_WD2);
        hit3    = wr && (addr == A_WD3);
        any_hit = hit1 || hit2 || hit3;
    end

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (hold) begin
            st_d.step  = WD_STEP0;
            st_d.presc = '0;
            st_d.win   = '0;
            st_d.pulse = 1'b0;
            st_d.plen  = '0;
        end else if (st_q.pulse) begin
            // reset pulse in progress: window frozen, writes ignored
            st_d.step  = WD_STEP0;
            st_d.presc = '0;
            st_d.win   = '0;
            if (st_q.plen == '0) begin
                st_d.pulse = 1'b0;
            end else begin
                st_d.plen = st_q.plen - LW'(1);
            end
        end else begin
            if (any_hit) begin
                case (st_q.step)
                    WD_STEP0: st_d.step = (hit1 && wdata == WD_VAL1) ? WD_STEP1 : WD_STEP0;
                    WD_STEP1: st_d.step = (hit2 && wdata == WD_VAL2) ? WD_STEP2 : WD_STEP0;
                    WD_STEP2: begin
                        done      = hit3 && (wdata == WD_VAL3);
                        st_d.step = WD_STEP0;
                    end
                    default:  st_d.step = WD_STEP0;
                endcase
            end
            if (done) begin
                st_d.presc = '0;
                st_d.win   = '0;
            end else if (st_q.presc == PRESC_LAST) begin
                st_d.presc = '0;
                if (st_q.win == WIN_LAST) begin
                    st_d.win   = '0;
                    st_d.pulse = 1'b1;
                    st_d.plen  = LEN_LOAD;
                    st_d.step  = WD_STEP0;
                end else begin
                    st_d.win = st_q.win + WW'(1);
                end
            end else begin
                st_d.presc = st_q.presc + PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{step: WD_STEP0, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign host_rst = st_q.pulse;

endmodule

// File: rtl/down_timer.sv
module down_timer #(
    parameter int TMR_PRESC = 100_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hi_wr,
    input  logic        lo_wr,
    input  logic [7:0]  wdata,
    output logic [15:0] count,
    output logic        expired
);

    localparam int TW = (TMR_PRESC > 1) ? $clog2(TMR_PRESC) : 1;
    localparam logic [TW-1:0] TP_LAST = TW'(TMR_PRESC - 1);

    typedef struct packed {
        logic [7:0]    stage;
        logic [15:0]   cnt;
        logic [TW-1:0] tp;
        logic          run;
        logic          flag;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic [15:0] load_val;

    always_comb begin
        st_d     = st_q;
        load_val = {st_q.stage, wdata};
        if (hi_wr) begin
            st_d.stage = wdata;
        end
        if (lo_wr) begin
            st_d.cnt  = load_val;
            st_d.tp   = '0;
            st_d.run  = (load_val != 16'd0);
            st_d.flag = (load_val == 16'd0);
        end else if (st_q.run) begin
            if (st_q.tp == TP_LAST) begin
                st_d.tp  = '0;
                st_d.cnt = st_q.cnt - 16'd1;
                if (st_q.cnt == 16'd1) begin
                    st_d.run  = 1'b0;
                    st_d.flag = 1'b1;
                end
            end else begin
                st_d.tp = st_q.tp + TW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count   = st_q.cnt;
    assign expired = st_q.flag;

endmodule

// File: rtl/cfg_guard.sv
module cfg_guard
    import cfg_guard_pkg::*;
#(
    parameter int         PRESC_DIV = 2_000_000,
    parameter int         WIN_TICKS = 100,
    parameter int         RST_LEN   = 16,
    parameter int         TMR_PRESC = 100_000,
    parameter logic [7:0] WD_VAL1   = 8'h5A,
    parameter logic [7:0] WD_VAL2   = 8'h99,
    parameter logic [7:0] WD_VAL3   = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              wd_disable,
    output logic              cfg_wr_ok,
    output logic              host_reset,
    output logic              tmr_expired
);

    typedef struct packed {
        logic [7:0] scr;
    } top_st_t;

    top_st_t     st_d, st_q;
    logic        key_wr, hi_wr, lo_wr;
    logic [15:0] tmr_count;

    always_comb begin
        key_wr = bus_wr && (bus_addr == A_KEY);
        hi_wr  = bus_wr && (bus_addr == A_TMR_HI);
        lo_wr  = bus_wr && (bus_addr == A_TMR_LO);
    end

    wp_key_unit u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .wdata    (bus_wdata),
        .unlocked (cfg_wr_ok)
    );

    wd_supervisor #(
        .PRESC_DIV (PRESC_DIV),
        .WIN_TICKS (WIN_TICKS),
        .RST_LEN   (RST_LEN),
        .WD_VAL1   (WD_VAL1),
        .WD_VAL2   (WD_VAL2),
        .WD_VAL3   (WD_VAL3)
    ) u_wd (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (wd_disable),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .host_rst (host_reset)
    );

    down_timer #(
        .TMR_PRESC (TMR_PRESC)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .hi_wr   (hi_wr),
        .lo_wr   (lo_wr),
        .wdata   (bus_wdata),
        .count   (tmr_count),
        .expired (tmr_expired)
    );

    // scratch byte, gated by the same qualifier as the protected bank
    always_comb begin
        st_d = st_q;
        if (bus_wr && (bus_addr == A_SCRATCH) && cfg_wr_ok) begin
            st_d.scr = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (bus_addr)
            A_SCRATCH: bus_rdata = st_q.scr;
            A_KEY:     bus_rdata = {7'd0, cfg_wr_ok};
            A_TMR_HI:  bus_rdata = tmr_count[15:8];
            A_TMR_LO:  bus_rdata = tmr_count[7:0];
            A_TFLAG:   bus_rdata = {7'd0, tmr_expired};
            default:   bus_rdata = 8'd0;
        endcase
    end

endmodule

// File: rtl/cfg_guard_chk.sv
module cfg_guard_chk #(
    parameter int RST_LEN = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  bus_addr,
    input logic        bus_wr,
    input logic [7:0]  bus_wdata,
    input logic        wd_disable,
    input logic        cfg_wr_ok,
    input logic        host_reset,
    input logic        tmr_expired,
    input logic [7:0]  scratch,
    input logic [15:0] tcount
);

    int hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= 0;
        end else begin
            hi_run <= host_reset ? hi_run + 1 : 0;
        end
    end

    p_unlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd1 && bus_wdata == 8'h95) |=> cfg_wr_ok);

    p_relock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd1 && bus_wdata != 8'h95) |=> !cfg_wr_ok);

    p_key_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 3'd1) |=> $stable(cfg_wr_ok));

    p_scratch_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 3'd0 && cfg_wr_ok) |=> $stable(scratch));

    p_pulse_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hi_run <= RST_LEN);

    p_disable_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wd_disable |=> !host_reset);

    p_zero_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tcount == 16'd0 && !(bus_wr && bus_addr == 3'd6)) |=> tcount == 16'd0);

    p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_expired && !(bus_wr && bus_addr == 3'd6)) |=> tmr_expired);

    p_flag_at_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_expired |-> tcount == 16'd0);

endmodule

bind cfg_guard cfg_guard_chk #(.RST_LEN(RST_LEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .wd_disable  (wd_disable),
    .cfg_wr_ok   (cfg_wr_ok),
    .host_reset  (host_reset),
    .tmr_expired (tmr_expired),
    .scratch     (st_q.scr),
    .tcount      (tmr_count)
);

// File: tb/tb_cfg_guard.sv
`timescale 1ns/1ps
module tb_cfg_guard;

    localparam int P   = 4;
    localparam int W   = 8;
    localparam int N   = P * W;
    localparam int RL  = 5;
    localparam int TP  = 3;
    localparam logic [7:0] K1 = 8'h5A;
    localparam logic [7:0] K2 = 8'h99;
    localparam logic [7:0] K3 = 8'hA5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       wd_disable = 1'b0;
    logic       cfg_wr_ok, host_reset, tmr_expired;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    bit model_on = 1'b0;

    always #5 clk = ~clk;

    cfg_guard #(
        .PRESC_DIV (P), .WIN_TICKS (W), .RST_LEN (RL), .TMR_PRESC (TP),
        .WD_VAL1 (K1), .WD_VAL2 (K2), .WD_VAL3 (K3)
    ) dut (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wr (bus_wr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .wd_disable (wd_disable),
        .cfg_wr_ok (cfg_wr_ok), .host_reset (host_reset), .tmr_expired (tmr_expired)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model, written from the requirements
    bit          m_unl;
    logic [7:0]  m_scr, m_stage;
    int          m_step, m_left, m_pulse, m_tp;
    logic [15:0] m_cnt;
    bit          m_flag;

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_scr;
            3'd1: return {7'd0, m_unl};
            3'd5: return m_cnt[15:8];
            3'd6: return m_cnt[7:0];
            3'd7: return {7'd0, m_flag};
            default: return 8'd0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [2:0] a);
        case (a)
            3'd0: return "R4 scratch read";
            3'd1: return "R2 key read";
            3'd5, 3'd6: return "R10 count read";
            3'd7: return "R12 flag read";
            default: return "R10 unmapped read";
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_unl = 0; m_scr = 0; m_stage = 0; m_step = 0; m_left = N;
            m_pulse = 0; m_tp = 0; m_cnt = 0; m_flag = 0;
        end else begin
            bit svc;
            if (bus_wr && bus_addr == 3'd0 && m_unl) m_scr = bus_wdata;
            if (bus_wr && bus_addr == 3'd1) m_unl = (bus_wdata == 8'h95);
            // watchdog
            if (wd_disable) begin
                m_step = 0; m_left = N; m_pulse = 0;
            end else if (m_pulse > 0) begin
                m_pulse--; m_step = 0;
                if (m_pulse == 0) m_left = N;
            end else begin
                svc = 0;
                if (bus_wr && bus_addr >= 3'd2 && bus_addr <= 3'd4) begin
                    if (m_step == 0)      m_step = (bus_addr == 3'd2 && bus_wdata == K1) ? 1 : 0;
                    else if (m_step == 1) m_step = (bus_addr == 3'd3 && bus_wdata == K2) ? 2 : 0;
                    else begin
                        svc = (bus_addr == 3'd4 && bus_wdata == K3);
                        m_step = 0;
                    end
                end
                if (svc) m_left = N;
                else begin
                    m_left--;
                    if (m_left == 0) begin m_pulse = RL; m_step = 0; end
                end
            end
            // timer
            if (bus_wr && bus_addr == 3'd5) m_stage = bus_wdata;
            if (bus_wr && bus_addr == 3'd6) begin
                m_cnt = {m_stage, bus_wdata}; m_tp = 0; m_flag = (m_cnt == 16'd0);
            end else if (m_cnt != 16'd0) begin
                if (m_tp == TP - 1) begin
                    m_tp = 0; m_cnt = m_cnt - 16'd1;
                    if (m_cnt == 16'd0) m_flag = 1;
                end else m_tp++;
            end
        end
    end

    always @(negedge clk) begin
        #2;
        if (model_on && rst_n) begin
            chk("R2 R3 qualifier", cfg_wr_ok, m_unl);
            chk("R7 R8 R9 host_reset", host_reset, (m_pulse > 0));
            chk("R11 timer flag", tmr_expired, m_flag);
            chk(rd_tag(bus_addr), bus_rdata, exp_rd(bus_addr));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic look(input logic [2:0] a);
        @(negedge clk);
        bus_addr = a;
        #3;
    endtask

    task automatic service();
        wr(3'd2, K1); wr(3'd3, K2); wr(3'd4, K3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        int t0, seen, len;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_on = 1'b1;
        #3;
        // R1 reset state
        chk("R1 qualifier", cfg_wr_ok, 1'b0);
        chk("R1 host_reset", host_reset, 1'b0);
        chk("R1 flag", tmr_expired, 1'b0);
        chk("R1 scratch", bus_rdata, 8'h00);
        look(3'd6);
        chk("R1 count low", bus_rdata, 8'h00);

        // R4 locked write ignored, R2 unlock, R3 relock
        wr(3'd0, 8'hC3); look(3'd0);
        chk("R4 locked scratch", bus_rdata, 8'h00);
        wr(3'd1, 8'h95); look(3'd1);
        chk("R2 unlocked", cfg_wr_ok, 1'b1);
        wr(3'd0, 8'h3C); look(3'd0);
        chk("R4 scratch write", bus_rdata, 8'h3C);
        wr(3'd1, 8'h94); look(3'd0);
        chk("R3 relocked", cfg_wr_ok, 1'b0);
        wr(3'd0, 8'hFF); look(3'd0);
        chk("R4 scratch kept", bus_rdata, 8'h3C);

        // R5 periodic service keeps host_reset low
        @(negedge clk); wd_disable = 1'b1;
        @(negedge clk); wd_disable = 1'b0;
        seen = 0;
        for (int i = 0; i < 6; i++) begin
            service();
            for (int j = 0; j < 20; j++) begin
                @(negedge clk); #3;
                if (host_reset) seen++;
            end
        end
        chk("R5 no reset while serviced", seen, 0);

        // R6 wrong value then late correct steps: no credit; R7 exact deadline
        @(negedge clk); wd_disable = 1'b1;
        @(negedge clk); wd_disable = 1'b0; t0 = cyc;
        wr(3'd2, K1); wr(3'd3, 8'h98); wr(3'd3, K2); wr(3'd4, K3);
        wr(3'd4, K3); wr(3'd3, K2);
        while (!host_reset) begin @(negedge clk); #3; end
        chk("R6 R7 expiry edge", cyc - t0, N);

        // R8 pulse width and rearm
        len = 0; t0 = 0;
        while (host_reset) begin len++; t0 = cyc; @(negedge clk); #3; end
        chk("R8 pulse length", len, RL);
        t0 = t0 + 1;
        while (!host_reset) begin @(negedge clk); #3; end
        chk("R8 rearm window", cyc - t0, N);
        while (host_reset) begin @(negedge clk); #3; end

        // R9 disable holds watchdog quiet
        @(negedge clk); wd_disable = 1'b1; seen = 0;
        for (int j = 0; j < 3 * N; j++) begin
            @(negedge clk); #3;
            if (host_reset) seen++;
        end
        chk("R9 no reset while disabled", seen, 0);

        // R10 R11 timer load and countdown
        wr(3'd5, 8'h00); wr(3'd6, 8'h05); t0 = cyc;
        while (!tmr_expired) begin @(negedge clk); #3; end
        chk("R11 zero after 5 steps", cyc - t0, 5 * TP);
        repeat (10) @(negedge clk);
        look(3'd6);
        chk("R12 flag sticky", tmr_expired, 1'b1);
        chk("R12 count held at zero", bus_rdata, 8'h00);
        wr(3'd5, 8'h01); bus_wdata = 8'h02; wr(3'd6, 8'h02);
        #3; bus_addr = 3'd5; #1;
        chk("R10 flag cleared by load", tmr_expired, 1'b0);
        chk("R10 high byte", bus_rdata, 8'h01);
        bus_addr = 3'd6; #1;
        chk("R10 low byte", bus_rdata, 8'h02);
        wr(3'd6, 8'h00); wr(3'd5, 8'h00); wr(3'd6, 8'h00); look(3'd7);
        chk("R11 load of zero flags", bus_rdata, 8'h01);

        // random traffic against the model
        for (int k = 0; k < 4000; k++) begin
            logic [7:0] d;
            int sel;
            @(negedge clk);
            sel = $urandom_range(0, 7);
            case (sel)
                0: d = 8'h95;
                1: d = K1;
                2: d = K2;
                3: d = K3;
                4: d = 8'h00;
                default: d = 8'($urandom);
            endcase
            bus_addr  = 3'($urandom_range(0, 7));
            bus_wdata = d;
            bus_wr    = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 199) == 0) wd_disable = ~wd_disable;
            if (k % 97 == 0) wd_disable = 1'b0;
        end
        @(negedge clk); bus_wr = 1'b0;
        repeat (5) @(negedge clk);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule